// File: doc/BRIEF.md
# Unaligned Word Merge Unit

This unit is the byte-merge datapath behind the four partial-word memory instructions: load-left, load-right, store-left and store-right. It is given the aligned memory word (the word fetched from the effective address with its low two bits forced to zero), the current register value, and the low bits of the effective address, which serve as a byte offset. For a load it combines memory bytes and register bytes into the new register value. For a store it combines register bytes and memory bytes into the word that goes back to the aligned address.

The unit is purely combinational and holds no state. Computing the address, running the bus cycles and sequencing read before write are left to the surrounding pipeline. The unit also applies the register-zero rule. A load whose destination is register 0 still produces its merged value, but the register write enable stays low. The memory read it depends on has already taken place upstream either way.

Top module: `uwm_merge`

## Requirements
- R1: With `req`=1 and `op`=0 (load-left), for byte offsets 0, 1, 2 and 3, `reg_out` equals (mem<<24)|(reg&0x00FFFFFF), (mem<<16)|(reg&0x0000FFFF), (mem<<8)|(reg&0x000000FF) and mem.
- R2: With `op`=1 (load-right), for offsets 0, 1, 2 and 3, `reg_out` equals mem, (mem>>8)|(reg&0xFF000000), (mem>>16)|(reg&0xFFFF0000) and (mem>>24)|(reg&0xFFFFFF00).
- R3: With `op`=2 (store-left), for offsets 0, 1, 2 and 3, `mem_out` equals (reg>>24)|(mem&0xFFFFFF00), (reg>>16)|(mem&0xFFFF0000), (reg>>8)|(mem&0xFF000000) and reg.
- R4: With `op`=3 (store-right), for offsets 0, 1, 2 and 3, `mem_out` equals reg, (reg<<8)|(mem&0x000000FF), (reg<<16)|(mem&0x0000FFFF) and (reg<<24)|(mem&0x00FFFFFF).
- R5: `reg_we` is 1 only for a requested load (`op` 0 or 1) whose `dest_idx` is not 0. For a load to register 0, `reg_out` still carries the merged value.
- R6: `mem_we` is 1 exactly for a requested store (`op` 2 or 3). `reg_we` and `mem_we` are never both 1.
- R7: For a store, `reg_out` equals `reg_in`. For a load, `mem_out` equals `mem_in`.
- R8: The boundary offsets pass a whole word through: load-left at offset 3 and load-right at offset 0 give `reg_out`=mem, and store-left at offset 3 and store-right at offset 0 give `mem_out`=reg.
- R9: With `req`=0, both `reg_we` and `mem_we` are 0 whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req | input | 1 | An instruction of this class is present this cycle |
| op | input | 2 | 0 load-left, 1 load-right, 2 store-left, 3 store-right |
| byte_off | input | 2 | Low bits of the effective address |
| dest_idx | input | 5 | Destination register index for loads |
| mem_in | input | 32 | Aligned memory word |
| reg_in | input | 32 | Current register value (load target or store source) |
| reg_out | output | 32 | Merged register value |
| reg_we | output | 1 | Register write enable |
| mem_out | output | 32 | Merged word for the aligned store |
| mem_we | output | 1 | Memory write enable |

## Verification
Two of the unit's functions meet in the same evaluation: the load merge and the register-zero suppression. The bench provokes this by sweeping every load variant and every offset with `dest_idx` set to 0 and to nonzero indices, over several data patterns. It judges the result by requiring `reg_out` to carry the arithmetically expected merge while `reg_we` follows the destination index alone and `mem_we` stays low.

// File: rtl/uwm_pkg.sv
// Package: shared operation encoding for the unaligned word merge unit.
// Assumes op values are fixed by the instruction decoder upstream.
package uwm_pkg;
    typedef enum logic [1:0] {
        OP_LD_LEFT  = 2'd0,
        OP_LD_RIGHT = 2'd1,
        OP_ST_LEFT  = 2'd2,
        OP_ST_RIGHT = 2'd3
    } uwm_op_e;
endpackage

// File: rtl/uwm_byte_shift.sv
// Module: shifts a word by a whole number of byte lanes, left or right,
// filling vacated lanes with zero. Assumes amt_i < LANES.
module uwm_byte_shift #(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    localparam int WORD_W = LANES * BYTE_W,
    localparam int AMT_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [WORD_W-1:0] data_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic              left_i,
    output logic [WORD_W-1:0] data_o
);
    // Per output lane: pick the source lane amt_i lanes away, or zero.
    always_comb begin
        data_o = '0;
        for (int i = 0; i < LANES; i++) begin
            if (left_i) begin
                if (i >= int'(amt_i))
                    data_o[i*BYTE_W +: BYTE_W] = data_i[(i-int'(amt_i))*BYTE_W +: BYTE_W];
            end else begin
                if (i + int'(amt_i) < LANES)
                    data_o[i*BYTE_W +: BYTE_W] = data_i[(i+int'(amt_i))*BYTE_W +: BYTE_W];
            end
        end
    end
endmodule

// File: rtl/uwm_lane_mask.sv
// Module: builds a bit mask covering `cnt_i` byte lanes taken either from
// the low end or from the high end of the word. Assumes cnt_i <= LANES.
module uwm_lane_mask #(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    localparam int WORD_W = LANES * BYTE_W,
    localparam int AMT_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [AMT_W-1:0]  cnt_i,
    input  logic              upper_i,
    output logic [WORD_W-1:0] mask_o
);
    // Mark each lane that falls inside the selected low or high run.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            if (upper_i)
                mask_o[i*BYTE_W +: BYTE_W] = (i >= LANES - int'(cnt_i)) ? '1 : '0;
            else
                mask_o[i*BYTE_W +: BYTE_W] = (i < int'(cnt_i)) ? '1 : '0;
        end
    end
endmodule

// File: rtl/uwm_merge.sv
// Module: unaligned word merge unit. Combines the aligned memory word and
// a register value byte-wise for the partial-word load/store instructions.
// Assumes LANES is a power of two and the memory word is already aligned.
module uwm_merge #(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 5,
    localparam int WORD_W = LANES * BYTE_W,
    localparam int OFF_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              req,
    input  logic [1:0]        op,
    input  logic [OFF_W-1:0]  byte_off,
    input  logic [IDX_W-1:0]  dest_idx,
    input  logic [WORD_W-1:0] mem_in,
    input  logic [WORD_W-1:0] reg_in,
    output logic [WORD_W-1:0] reg_out,
    output logic              reg_we,
    output logic [WORD_W-1:0] mem_out,
    output logic              mem_we
);
    import uwm_pkg::*;

    localparam logic [OFF_W-1:0] TOP_LANE = OFF_W'(LANES - 1);

    logic              is_store;
    logic              is_left_op;
    logic              shift_left;
    logic              keep_upper;
    logic [OFF_W-1:0]  lane_cnt;
    logic [WORD_W-1:0] src_word;
    logic [WORD_W-1:0] other_word;
    logic [WORD_W-1:0] shifted;
    logic [WORD_W-1:0] keep_mask;
    logic [WORD_W-1:0] merged;

    // Decode the operation into shift direction, count and keep side.
    always_comb begin
        is_store   = op[1];
        is_left_op = (op == OP_LD_LEFT) || (op == OP_ST_LEFT);
        shift_left = (op == OP_LD_LEFT) || (op == OP_ST_RIGHT);
        keep_upper = !shift_left;
        lane_cnt   = is_left_op ? (TOP_LANE - byte_off) : byte_off;
        src_word   = is_store ? reg_in : mem_in;
        other_word = is_store ? mem_in : reg_in;
    end

    uwm_byte_shift #(.LANES(LANES), .BYTE_W(BYTE_W)) u_shift (
        .data_i (src_word),
        .amt_i  (lane_cnt),
        .left_i (shift_left),
        .data_o (shifted)
    );

    uwm_lane_mask #(.LANES(LANES), .BYTE_W(BYTE_W)) u_mask (
        .cnt_i   (lane_cnt),
        .upper_i (keep_upper),
        .mask_o  (keep_mask)
    );

    // Merge shifted bytes with the retained bytes of the other word.
    always_comb merged = shifted | (other_word & keep_mask);

    // Route the merge to the proper output and form write enables.
    always_comb begin
        reg_out = is_store ? reg_in : merged;
        mem_out = is_store ? merged : mem_in;
        reg_we  = req && !is_store && (dest_idx != '0);
        mem_we  = req && is_store;
    end

    // Output checks that relate the separately built pieces.
    always_comb begin
        if (req && op == OP_LD_LEFT && byte_off == TOP_LANE)
            AST_LDL_FULL_WORD: assert (reg_out == mem_in); // R8
        if (req && op == OP_ST_RIGHT && byte_off == '0)
            AST_STR_FULL_WORD: assert (mem_out == reg_in); // R8
        if (dest_idx == '0)
            AST_ZERO_DEST_NO_WE: assert (!reg_we); // R5
        AST_WE_EXCLUSIVE: assert (!(reg_we && mem_we)); // R6
        if (!req)
            AST_IDLE_NO_WE: assert (!reg_we && !mem_we); // R9
        if (op[1])
            AST_STORE_REG_PASS: assert (reg_out == reg_in); // R7
    end
endmodule

// File: tb/sim_uwm_merge.sv
module sim_uwm_merge;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        req;
    logic [1:0]  op;
    logic [1:0]  byte_off;
    logic [4:0]  dest_idx;
    logic [31:0] mem_in;
    logic [31:0] reg_in;
    logic [31:0] reg_out;
    logic        reg_we;
    logic [31:0] mem_out;
    logic        mem_we;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uwm_merge u0 (
        .req(req), .op(op), .byte_off(byte_off), .dest_idx(dest_idx),
        .mem_in(mem_in), .reg_in(reg_in),
        .reg_out(reg_out), .reg_we(reg_we), .mem_out(mem_out), .mem_we(mem_we)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s op=%0d off=%0d dest=%0d actual=%h expected=%h",
                     tag, op, byte_off, dest_idx, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_load(input logic [1:0] o, input logic [1:0] k,
                                             input logic [31:0] m, input logic [31:0] r);
        if (o == 2'd0) begin
            case (k)
                2'd0: return (m << 24) | (r & 32'h00FFFFFF);
                2'd1: return (m << 16) | (r & 32'h0000FFFF);
                2'd2: return (m << 8)  | (r & 32'h000000FF);
                default: return m;
            endcase
        end
        case (k)
            2'd0: return m;
            2'd1: return (m >> 8)  | (r & 32'hFF000000);
            2'd2: return (m >> 16) | (r & 32'hFFFF0000);
            default: return (m >> 24) | (r & 32'hFFFFFF00);
        endcase
    endfunction

    function automatic logic [31:0] exp_store(input logic [1:0] o, input logic [1:0] k,
                                              input logic [31:0] m, input logic [31:0] r);
        if (o == 2'd2) begin
            case (k)
                2'd0: return (r >> 24) | (m & 32'hFFFFFF00);
                2'd1: return (r >> 16) | (m & 32'hFFFF0000);
                2'd2: return (r >> 8)  | (m & 32'hFF000000);
                default: return r;
            endcase
        end
        case (k)
            2'd0: return r;
            2'd1: return (r << 8)  | (m & 32'h000000FF);
            2'd2: return (r << 16) | (m & 32'h0000FFFF);
            default: return (r << 24) | (m & 32'h00FFFFFF);
        endcase
    endfunction

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] mpat [4];
        logic [31:0] rpat [4];
        logic [4:0]  dpat [3];
        mpat[0] = 32'h11223344; rpat[0] = 32'hAABBCCDD;
        mpat[1] = 32'h00000000; rpat[1] = 32'hFFFFFFFF;
        mpat[2] = 32'hFFFFFFFF; rpat[2] = 32'h00000000;
        mpat[3] = 32'h8091A2B3; rpat[3] = 32'h5E6F7081;
        dpat[0] = 5'd0; dpat[1] = 5'd1; dpat[2] = 5'd31;

        // Idle state: no request, enables low (R9)
        req = 1'b0; op = 2'd0; byte_off = 2'd0; dest_idx = 5'd7;
        mem_in = 32'h12345678; reg_in = 32'h9ABCDEF0;
        @(negedge clk);
        check("R9 idle reg_we", {31'b0, reg_we}, 32'd0);
        check("R9 idle mem_we", {31'b0, mem_we}, 32'd0);
        for (int o = 0; o < 4; o++) begin
            op = 2'(o);
            @(negedge clk);
            check("R9 idle sweep we", {30'b0, reg_we, mem_we}, 32'd0);
        end

        req = 1'b1;
        for (int o = 0; o < 4; o++) begin
            for (int k = 0; k < 4; k++) begin
                for (int p = 0; p < 4; p++) begin
                    for (int d = 0; d < 3; d++) begin
                        op = 2'(o); byte_off = 2'(k); dest_idx = dpat[d];
                        mem_in = mpat[p]; reg_in = rpat[p];
                        @(negedge clk);
                        if (o < 2) begin
                            check(o == 0 ? "R1 load-left" : "R2 load-right",
                                  reg_out, exp_load(2'(o), 2'(k), mpat[p], rpat[p]));
                            check("R5 reg_we", {31'b0, reg_we}, {31'b0, dpat[d] != 5'd0});
                            check("R6 load mem_we", {31'b0, mem_we}, 32'd0);
                            check("R7 load mem pass", mem_out, mpat[p]);
                        end else begin
                            check(o == 2 ? "R3 store-left" : "R4 store-right",
                                  mem_out, exp_store(2'(o), 2'(k), mpat[p], rpat[p]));
                            check("R6 store we", {30'b0, reg_we, mem_we}, 32'd1);
                            check("R7 store reg pass", reg_out, rpat[p]);
                        end
                    end
                end
            end
        end

        // Boundary offsets give a whole word (R8)
        mem_in = 32'hCAFEF00D; reg_in = 32'h0BADBEEF; dest_idx = 5'd3;
        op = 2'd0; byte_off = 2'd3; @(negedge clk);
        check("R8 load-left off3", reg_out, 32'hCAFEF00D);
        op = 2'd1; byte_off = 2'd0; @(negedge clk);
        check("R8 load-right off0", reg_out, 32'hCAFEF00D);
        op = 2'd2; byte_off = 2'd3; @(negedge clk);
        check("R8 store-left off3", mem_out, 32'h0BADBEEF);
        op = 2'd3; byte_off = 2'd0; @(negedge clk);
        check("R8 store-right off0", mem_out, 32'h0BADBEEF);

        // Drop request mid-stream: enables fall (R9)
        req = 1'b0; op = 2'd0; @(negedge clk);
        check("R9 drop reg_we", {31'b0, reg_we}, 32'd0);
        op = 2'd3; @(negedge clk);
        check("R9 drop mem_we", {31'b0, mem_we}, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule